// File: doc/BRIEF.md
# Node State Register Controller

This block keeps the 32-bit state word of a serial-bus node and the cycle-start enable that goes with it. A register access port issues read, bit-set and bit-clear requests. Only three bits of the word can change: abdicate, cycle master and request-disable. A bit-set request ORs the incoming word into those bits, and a bit-clear request clears those bits wherever the incoming word has a one. A constant node-capabilities word is also available on the port side.

A bus-reset pulse runs a small root-tracking machine. The machine remembers whether the node was root at the previous reset. It uses that flag, the live "is root" input and the "cycle-master capable" input to decide three things: whether cycle mastering starts, whether it stops, or whether it is left as it was. Every reset drops the abdicate bit. While the node is root, writes to the cycle-master bit also switch cycle-start generation on or off.

Top module: `nsr_node_state`

## Requirements
- R1: `reqOp` is encoded as 00 = read, 01 = bit-set, 10 = bit-clear, 11 = no operation. A bit-set with `reqValid` ORs `reqData` into the state word, but only at the writable positions: bit 10 (abdicate), bit 8 (cycle master) and bit 0 (request-disable), which together form mask 0x00000501. Every other bit always reads 0.
- R2: A bit-clear with `reqValid` clears each writable bit whose `reqData` bit is 1. `reqData` bits outside the writable positions have no effect.
- R3: A bit-set or bit-clear that touches bit 8 while `isRoot` is 1 drives `cycleStartEn` to 1 (set) or 0 (clear) from the next cycle. When `isRoot` is 0, such a request leaves `cycleStartEn` unchanged.
- R4: Every `busReset` pulse clears the abdicate bit (bit 10).
- R5: A bus reset while `isRoot` is 0 clears the remembered was-root flag and the cycle-master bit. It leaves `cycleStartEn` unchanged.
- R6: A bus reset while `isRoot` is 1 and the was-root flag is 0 sets the was-root flag. If `cmCapable` is 1, it also sets the cycle-master bit and drives `cycleStartEn` to 1. Otherwise it clears the bit and drives `cycleStartEn` to 0.
- R7: A bus reset while `isRoot` is 1 and the was-root flag is already 1 leaves the cycle-master bit and `cycleStartEn` unchanged.
- R8: After `rstN` is low, the state word is 0, the was-root flag is 0 and `cycleStartEn` is 0. `capWord` always reads 0x000083C0.
- R9: A read with `reqValid` makes `rdValid` high for exactly the next cycle. In that cycle `rdData` holds the state word as it stood when the request was made. `rdValid` is low in every other cycle.
- R10: When a bus reset and a bit-set or bit-clear arrive in the same cycle, the bus-reset update is applied first and the request is applied on top of its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqOp | input | 2 | Request kind: 00 read, 01 set, 10 clear, 11 none |
| reqData | input | 32 | Set or clear mask |
| busReset | input | 1 | One-cycle bus-reset pulse |
| isRoot | input | 1 | Node is currently root |
| cmCapable | input | 1 | Node can act as cycle master |
| rdData | output | 32 | Registered read data |
| rdValid | output | 1 | One-cycle read strobe |
| cycleStartEn | output | 1 | Cycle-start generation enable |
| capWord | output | 32 | Constant node-capabilities word |

## Verification
A bus-reset pulse and a bit-set or bit-clear request can land in the same cycle. In that case the reset's forced cycle-master and abdicate values compete with the request's mask. Directed steps raise a reset together with a set of the abdicate bit, and a reset together with a clear of the cycle-master bit on a newly root node. Random stimulus then pairs resets with requests about one step in eight. Each outcome is judged by a later read and by `cycleStartEn`, against a bench model that applies the reset rules first and the request second.

// File: rtl/nsr_pkg.sv
package nsr_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_NONE  = 2'b11
  } nsrOp_e;

  // Strobes from control to datapath for one cycle
  typedef struct packed {
    logic rdStb;    // capture current word for read-out
    logic setStb;   // apply OR mask
    logic clrStb;   // apply clear mask
    logic abdClr;   // reset: drop abdicate
    logic cmSet;    // reset: force cycle master on
    logic cmClr;    // reset: force cycle master off
    logic enOn;     // reset: start cycle starts
    logic enOff;    // reset: stop cycle starts
    logic rootNow;  // node is root this cycle
  } nsrStrobe_t;

endpackage

// File: rtl/nsr_ctrl.sv
module nsr_ctrl
  import nsr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqOp,
  input  logic       busReset,
  input  logic       isRoot,
  input  logic       cmCapable,
  output nsrStrobe_t stb,
  output logic       wasRootQ
);

  logic wasRootD;

  always_comb begin
    stb         = '0;
    stb.rootNow = isRoot;
    wasRootD    = wasRootQ;

    if (reqValid) begin
      unique case (nsrOp_e'(reqOp))
        OP_READ:  stb.rdStb  = 1'b1;
        OP_SET:   stb.setStb = 1'b1;
        OP_CLEAR: stb.clrStb = 1'b1;
        default:  ;
      endcase
    end

    if (busReset) begin
      stb.abdClr = 1'b1;
      if (!isRoot) begin
        // link halts cycle starts on its own; enable left alone
        wasRootD  = 1'b0;
        stb.cmClr = 1'b1;
      end else if (!wasRootQ) begin
        wasRootD = 1'b1;
        if (cmCapable) begin
          stb.cmSet = 1'b1;
          stb.enOn  = 1'b1;
        end else begin
          stb.cmClr = 1'b1;
          stb.enOff = 1'b1;
        end
      end
      // root before and root now: cycle master untouched
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) wasRootQ <= 1'b0;
    else       wasRootQ <= wasRootD;
  end

endmodule

// File: rtl/nsr_datapath.sv
module nsr_datapath
  import nsr_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int ABD_BIT  = 10,
  parameter int CM_BIT   = 8,
  parameter int DREQ_BIT = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  nsrStrobe_t       stb,
  input  logic [WIDTH-1:0] reqData,
  output logic [WIDTH-1:0] stateQ,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             cycleStartEn
);

  logic [WIDTH-1:0] writeMask;
  logic [WIDTH-1:0] reqMask;
  logic [WIDTH-1:0] afterReset;
  logic [WIDTH-1:0] stateD;
  logic             enAfterReset;
  logic             enD;

  for (genvar i = 0; i < WIDTH; i++) begin : g_mask
    assign writeMask[i] = (i == ABD_BIT) || (i == CM_BIT) || (i == DREQ_BIT);
  end

  assign reqMask = reqData & writeMask;

  // stage 1: bus-reset effects
  always_comb begin
    afterReset   = stateQ;
    enAfterReset = cycleStartEn;
    if (stb.abdClr) afterReset[ABD_BIT] = 1'b0;
    if (stb.cmSet)  afterReset[CM_BIT]  = 1'b1;
    if (stb.cmClr)  afterReset[CM_BIT]  = 1'b0;
    if (stb.enOn)   enAfterReset        = 1'b1;
    if (stb.enOff)  enAfterReset        = 1'b0;
  end

  // stage 2: access request on top of the reset result
  always_comb begin
    stateD = afterReset;
    enD    = enAfterReset;
    if (stb.setStb) begin
      stateD = afterReset | reqMask;
      if (reqMask[CM_BIT] && stb.rootNow) enD = 1'b1;
    end else if (stb.clrStb) begin
      stateD = afterReset & ~reqMask;
      if (reqMask[CM_BIT] && stb.rootNow) enD = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ       <= '0;
      cycleStartEn <= 1'b0;
      rdData       <= '0;
      rdValid      <= 1'b0;
    end else begin
      stateQ       <= stateD;
      cycleStartEn <= enD;
      rdValid      <= stb.rdStb;
      if (stb.rdStb) rdData <= stateQ;
    end
  end

endmodule

// File: rtl/nsr_node_state.sv
module nsr_node_state
  import nsr_pkg::*;
#(
  parameter int              WIDTH    = 32,
  parameter int              ABD_BIT  = 10,
  parameter int              CM_BIT   = 8,
  parameter int              DREQ_BIT = 0,
  parameter logic [WIDTH-1:0] CAP_WORD = 32'h0000_83C0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [1:0]       reqOp,
  input  logic [WIDTH-1:0] reqData,
  input  logic             busReset,
  input  logic             isRoot,
  input  logic             cmCapable,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             cycleStartEn,
  output logic [WIDTH-1:0] capWord
);

  nsrStrobe_t       stb;
  logic             wasRootQ;
  logic [WIDTH-1:0] stateQ;

  nsr_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqOp     (reqOp),
    .busReset  (busReset),
    .isRoot    (isRoot),
    .cmCapable (cmCapable),
    .stb       (stb),
    .wasRootQ  (wasRootQ)
  );

  nsr_datapath #(
    .WIDTH    (WIDTH),
    .ABD_BIT  (ABD_BIT),
    .CM_BIT   (CM_BIT),
    .DREQ_BIT (DREQ_BIT)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .reqData      (reqData),
    .stateQ       (stateQ),
    .rdData       (rdData),
    .rdValid      (rdValid),
    .cycleStartEn (cycleStartEn)
  );

  assign capWord = CAP_WORD;

endmodule

// File: rtl/nsr_node_state_chk.sv
module nsr_node_state_chk
  import nsr_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int ABD_BIT  = 10,
  parameter int CM_BIT   = 8,
  parameter int DREQ_BIT = 0
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       reqOp,
  input logic [WIDTH-1:0] reqData,
  input logic             busReset,
  input logic             isRoot,
  input logic             cmCapable,
  input logic             rdValid,
  input logic [WIDTH-1:0] rdData,
  input logic             cycleStartEn,
  input logic [WIDTH-1:0] stateQ,
  input logic             wasRootQ
);

  logic isRead, isSet, isClr, touchCm, quiet;
  logic [WIDTH-1:0] fixedMask;

  always_comb begin
    fixedMask = '1;
    fixedMask[ABD_BIT]  = 1'b0;
    fixedMask[CM_BIT]   = 1'b0;
    fixedMask[DREQ_BIT] = 1'b0;
  end

  assign isRead  = reqValid && (reqOp == OP_READ);
  assign isSet   = reqValid && (reqOp == OP_SET);
  assign isClr   = reqValid && (reqOp == OP_CLEAR);
  assign touchCm = (isSet || isClr) && reqData[CM_BIT];
  assign quiet   = !busReset && !isSet && !isClr;

  AST_FIXED_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ & fixedMask) == '0); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    quiet |=> $stable(stateQ)); // R2

  AST_SET_CM_ROOT: assert property (@(posedge clk) disable iff (!rstN)
    (isSet && reqData[CM_BIT] && isRoot) |=> cycleStartEn); // R3

  AST_CLR_CM_ROOT: assert property (@(posedge clk) disable iff (!rstN)
    (isClr && reqData[CM_BIT] && isRoot) |=> !cycleStartEn); // R3

  AST_RESET_DROPS_ABD: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !(isSet && reqData[ABD_BIT])) |=> !stateQ[ABD_BIT]); // R4

  AST_NOTROOT_CM: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !isRoot && !(isSet && reqData[CM_BIT])) |=> !stateQ[CM_BIT] && !wasRootQ); // R5

  AST_NOTROOT_EN: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && !isRoot) |=> cycleStartEn == $past(cycleStartEn)); // R5

  AST_NEWROOT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && isRoot && !wasRootQ && cmCapable && !touchCm) |=> cycleStartEn && stateQ[CM_BIT]); // R6

  AST_OLDROOT_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (busReset && isRoot && wasRootQ && !touchCm) |=> stateQ[CM_BIT] == $past(stateQ[CM_BIT])); // R7

  AST_RD_DATA: assert property (@(posedge clk) disable iff (!rstN)
    isRead |=> rdValid && (rdData == $past(stateQ))); // R9

  AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !isRead |=> !rdValid); // R9

endmodule

bind nsr_node_state nsr_node_state_chk #(
  .WIDTH    (WIDTH),
  .ABD_BIT  (ABD_BIT),
  .CM_BIT   (CM_BIT),
  .DREQ_BIT (DREQ_BIT)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .reqOp        (reqOp),
  .reqData      (reqData),
  .busReset     (busReset),
  .isRoot       (isRoot),
  .cmCapable    (cmCapable),
  .rdValid      (rdValid),
  .rdData       (rdData),
  .cycleStartEn (cycleStartEn),
  .stateQ       (stateQ),
  .wasRootQ     (wasRootQ)
);

// File: tb/nsr_node_state_tb.sv
module nsr_node_state_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqOp;
  logic [31:0] reqData;
  logic        busReset;
  logic        isRoot;
  logic        cmCapable;
  logic [31:0] rdData;
  logic        rdValid;
  logic        cycleStartEn;
  logic [31:0] capWord;

  int compared = 0;
  int mismatched = 0;

  // bench model state
  logic [31:0] mState;
  logic        mWas;
  logic        mEn;

  always #5 clk = ~clk;

  nsr_node_state u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqOp        (reqOp),
    .reqData      (reqData),
    .busReset     (busReset),
    .isRoot       (isRoot),
    .cmCapable    (cmCapable),
    .rdData       (rdData),
    .rdValid      (rdValid),
    .cycleStartEn (cycleStartEn),
    .capWord      (capWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // One clock: drive at negedge, model the edge, check at the next negedge.
  task automatic step(input logic v, input logic [1:0] op, input logic [31:0] d,
                      input logic br, input logic rt, input logic cp, input string req);
    logic [31:0] oldState;
    logic [31:0] m;
    logic        rdExp;
    reqValid = v; reqOp = op; reqData = d;
    busReset = br; isRoot = rt; cmCapable = cp;
    oldState = mState;
    rdExp = v && (op == 2'b00);
    // reset rules first (R10)
    if (br) begin
      mState[10] = 1'b0;
      if (!rt) begin
        mWas = 1'b0; mState[8] = 1'b0;
      end else if (!mWas) begin
        mWas = 1'b1; mState[8] = cp; mEn = cp;
      end
    end
    m = d & 32'h0000_0501;
    if (v && op == 2'b01) begin
      mState = mState | m;
      if (m[8] && rt) mEn = 1'b1;
    end else if (v && op == 2'b10) begin
      mState = mState & ~m;
      if (m[8] && rt) mEn = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; busReset = 1'b0;
    check(req, {31'd0, cycleStartEn}, {31'd0, mEn});
    check("R9", {31'd0, rdValid}, {31'd0, rdExp});
    if (rdExp) check(req, rdData, oldState);
  endtask

  task automatic readBack(input string req);
    step(1'b1, 2'b00, 32'h0, 1'b0, isRoot, cmCapable, req);
  endtask

  initial begin
    #1_500_000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; reqValid = 1'b0; reqOp = 2'b11; reqData = '0;
    busReset = 1'b0; isRoot = 1'b0; cmCapable = 1'b1;
    mState = '0; mWas = 1'b0; mEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R8: reset values and constant capability word
    check("R8", {31'd0, cycleStartEn}, 32'd0);
    check("R8", capWord, 32'h0000_83C0);
    readBack("R8");

    // R1: set all ones, only writable bits land; not root so enable stays (R3)
    step(1'b1, 2'b01, 32'hFFFF_FFFF, 1'b0, 1'b0, 1'b1, "R1");
    readBack("R1");
    // R2: clear with junk outside writable bits
    step(1'b1, 2'b10, 32'hF0F0_F100, 1'b0, 1'b0, 1'b1, "R2");
    readBack("R2");
    // R3: cycle-master set/clear while root drives enable
    step(1'b1, 2'b01, 32'h0000_0100, 1'b0, 1'b1, 1'b1, "R3");
    step(1'b1, 2'b10, 32'h0000_0100, 1'b0, 1'b1, 1'b1, "R3");
    // op 11 is ignored
    step(1'b1, 2'b11, 32'hFFFF_FFFF, 1'b0, 1'b1, 1'b1, "R1");
    readBack("R1");
    // R6 and R4: new root, capable; abdicate dropped
    step(1'b1, 2'b01, 32'h0000_0400, 1'b0, 1'b0, 1'b1, "R1");
    step(1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 1'b1, "R6");
    readBack("R4");
    // R7: clear cm while not root (enable kept), then reset as old root
    step(1'b1, 2'b10, 32'h0000_0100, 1'b0, 1'b0, 1'b1, "R3");
    step(1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 1'b1, "R7");
    readBack("R7");
    // R5: reset while not root, enable untouched
    step(1'b1, 2'b01, 32'h0000_0100, 1'b0, 1'b1, 1'b1, "R3");
    step(1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, "R5");
    readBack("R5");
    // R6: new root, not capable
    step(1'b0, 2'b11, 32'h0, 1'b1, 1'b1, 1'b0, "R6");
    readBack("R6");
    // R10: reset together with set of abdicate
    step(1'b1, 2'b01, 32'h0000_0401, 1'b1, 1'b1, 1'b1, "R10");
    readBack("R10");
    // R10: new root capable with clear of cm in same cycle
    step(1'b0, 2'b11, 32'h0, 1'b1, 1'b0, 1'b1, "R5");
    step(1'b1, 2'b10, 32'h0000_0100, 1'b1, 1'b1, 1'b1, "R10");
    readBack("R10");

    // constrained random mix
    for (int i = 0; i < 4000; i++) begin
      logic        v, br, rt, cp;
      logic [1:0]  op;
      logic [31:0] d;
      v  = ($urandom % 4) != 0;
      op = 2'($urandom % 4);
      d  = ($urandom % 2) ? $urandom : (32'h0000_0501 & $urandom);
      br = ($urandom % 8) == 0;
      rt = ($urandom % 3) != 0;
      cp = ($urandom % 5) != 0;
      step(v, op, d, br, rt, cp, (br && v && op[0] != op[1]) ? "R10" : "R1");
    end
    readBack("R1");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule